// File: doc/BRIEF.md
# Register-Addressed Block Transfer Controller

This controller runs whole block reads and block writes against a register-addressed two-wire serial device. A requester gives a 7-bit device address, a register address, a length of up to 255 bytes and a direction, then pulses `go`. The controller breaks the transfer into byte operations and hands them one at a time to an underlying byte engine. The byte engine does the bit-level work on the wire and answers each operation with an acknowledge result or a received byte. Write data is pulled from a show-ahead byte source. Read data is pushed out as a stream of strobed bytes. At the end the controller gives a one-cycle completion pulse and a held success flag.

In normal mode, a read addresses the device for writing and sends the register address. It then waits a bus-free interval and issues a repeated START with the read address; it does not send a STOP first. The controller also has a legacy mode for a device that answers to every device code. In that mode the register address travels in the upper seven bits of the first byte, next to the read/write bit, and no separate register byte is sent.

Writes go out in chunks of at most four bytes. Each chunk is a complete START-to-STOP exchange. After each chunk, the controller polls the device with its read address until the device stops refusing it, because the device refuses its address while an internal write cycle runs. The number of poll attempts is limited. Any refused address or data byte ends the transfer with a STOP and a failure result. The requester must handle page boundaries.

States: `S_IDLE` waits for `go`. `S_ADDR_W` sends START and the first address byte. `S_REG` sends the register byte. `S_GAP` waits the bus-free interval. `S_ADDR_R` sends the repeated START with the read address. `S_RX` receives data. `S_DATA` sends write data. `S_CHUNK_STOP` ends a chunk. `S_POLL` sends a polling START with the read address. `S_POLL_STOP` ends a refused poll. `S_POLL_RD` reads and discards one byte. `S_FAIL_STOP` issues the abort STOP. `S_FINISH` gives the completion pulse.

The transitions are as follows:
- Idle to finish when the length is zero; otherwise idle to first address.
- From first address: to register byte in normal mode, to receive for a legacy read, or to data for a legacy write.
- From register byte: to gap for a read, or to data for a write.
- Gap to repeated-START address.
- Repeated-START address to receive.
- Receive loops until the last byte, then goes to finish.
- Data loops until the chunk is used up, then goes to chunk stop.
- Chunk stop to poll.
- On a refusal, poll goes to poll stop (and back to poll), or to abort when attempts are used up.
- On acceptance, poll goes to poll read.
- Poll read goes to the next chunk's first address, or to finish.
- Any refusal in the first address, register byte, repeated-START address or data state goes to abort STOP.
- Abort STOP goes to finish.
- Finish goes to idle.

Top module: `regblk_xfer`

## Requirements
- R1: In normal mode, a read issues these operations in order: START with byte {dev,0}, the register byte, then START with byte {dev,1}. No STOP comes between them. The repeated START is requested no sooner than GAP_CYCLES cycles after the register byte is requested.
- R2: In legacy mode, the first operation of a transfer is START with byte {reg[6:0], rw}, where rw is 1 for a read and 0 for a write. No separate register byte follows.
- R3: When a START byte or a data byte is refused, the next operation is a STOP. The transfer then ends with xfer_ok = 0.
- R4: A read of N bytes issues N-1 receive-with-ACK operations followed by one receive-with-NACK-then-STOP operation. Each received byte appears on rd_byte with a one-cycle rd_valid, in order.
- R5: A write sends at most 4 data bytes per chunk. Each chunk has its own START, address bytes and STOP. The register address of each chunk is the previous one plus the previous chunk's length. Each accepted data byte is popped from the source with wr_pop.
- R6: After each chunk's STOP, the controller sends START with {dev,1}. Each refusal is followed by a STOP and a new attempt. After POLL_LIMIT (100) refused attempts, the transfer fails.
- R7: When a poll is accepted, the controller issues one receive-with-NACK-then-STOP operation. Its byte is discarded and never raises rd_valid.
- R8: A refused data byte aborts the whole transfer: no later chunk is started, and xfer_ok is 0.
- R9: A transfer of length 0 completes with xfer_ok = 1 and issues no byte-engine operation.
- R10: Engine operation codes on eng_op are: 0 = START then send byte, 1 = send byte, 2 = receive with ACK, 3 = receive with NACK then STOP, 4 = STOP. eng_req, eng_op and eng_tx_byte stay steady until eng_done.
- R11: xfer_done pulses for one cycle at the end of every transfer, and busy is low the cycle after. xfer_ok holds the result until the next go. Reset leaves busy, xfer_done and eng_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, sampled when idle |
| is_read | input | 1 | 1 = block read, 0 = block write |
| legacy | input | 1 | Selects legacy addressing |
| dev_addr | input | 7 | Device address |
| reg_addr | input | 8 | Starting register address |
| len | input | 8 | Byte count, 0 to 255 |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_ok | output | 1 | Result of last transfer |
| wr_byte | input | 8 | Show-ahead write data |
| wr_pop | output | 1 | Write byte consumed |
| rd_byte | output | 8 | Read data |
| rd_valid | output | 1 | Read data strobe |
| eng_req | output | 1 | Byte operation request |
| eng_op | output | 3 | Byte operation code |
| eng_tx_byte | output | 8 | Byte to send |
| eng_done | input | 1 | Operation finished pulse |
| eng_nack | input | 1 | Sent byte was refused (valid with eng_done) |
| eng_rx_byte | input | 8 | Received byte (valid with eng_done) |

## Verification
The hardest case to reach from the ports is the poll-retry limit. The device must keep refusing its address for at least a hundred consecutive polls, while data chunks and the discarded poll read must still behave correctly when the busy period is shorter. The bench's device model has a programmable number of refusals that follow every chunk's STOP. It is set to a few for the chunking test and to more than the limit for the exhaustion test. The bench then compares the full logged operation sequence against one it builds from the requirements. The same log shows the repeated START in reads, with no STOP in between and the bus-free spacing measured.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    typedef enum logic [2:0] {
        OP_START_TX = 3'd0,
        OP_TX       = 3'd1,
        OP_RX_ACK   = 3'd2,
        OP_RX_LAST  = 3'd3,
        OP_STOP     = 3'd4
    } eng_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_W,
        S_REG,
        S_GAP,
        S_ADDR_R,
        S_RX,
        S_DATA,
        S_CHUNK_STOP,
        S_POLL,
        S_POLL_STOP,
        S_POLL_RD,
        S_FAIL_STOP,
        S_FINISH
    } xfer_state_e;

endpackage

// File: rtl/regblk_gap_timer.sv
module regblk_gap_timer #(
    parameter int GAP_CYCLES = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (arm) begin
            cnt     <= CW'(GAP_CYCLES - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expired = running && (cnt == '0);
endmodule

// File: rtl/regblk_retry_ctr.sv
module regblk_retry_ctr #(
    parameter int POLL_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_try
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    logic [CW-1:0] tries;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (clr) begin
            tries <= '0;
        end else if (inc) begin
            tries <= tries + 1'b1;
        end
    end

    assign last_try = (tries == CW'(POLL_LIMIT - 1));
endmodule

// File: rtl/regblk_xfer.sv
module regblk_xfer
    import regblk_pkg::*;
#(
    parameter int CHUNK_MAX  = 4,
    parameter int POLL_LIMIT = 100,
    parameter int GAP_CYCLES = 6000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       is_read,
    input  logic       legacy,
    input  logic [6:0] dev_addr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] len,
    output logic       busy,
    output logic       xfer_done,
    output logic       xfer_ok,
    input  logic [7:0] wr_byte,
    output logic       wr_pop,
    output logic [7:0] rd_byte,
    output logic       rd_valid,
    output logic       eng_req,
    output logic [2:0] eng_op,
    output logic [7:0] eng_tx_byte,
    input  logic       eng_done,
    input  logic       eng_nack,
    input  logic [7:0] eng_rx_byte
);
    localparam int CCW = $clog2(CHUNK_MAX + 1);

    xfer_state_e st, st_nx;

    logic           rd_q;
    logic           leg_q;
    logic [6:0]     dev_q;
    logic [7:0]     cur_reg;
    logic [7:0]     remain;
    logic [CCW-1:0] chunk_left;
    logic           ok_q;

    logic           gap_arm;
    logic           gap_expired;
    logic           poll_clr;
    logic           poll_inc;
    logic           last_try;
    eng_op_e        op_sel;

    function automatic logic [CCW-1:0] chunk_of(input logic [7:0] n);
        if (n >= 8'(CHUNK_MAX)) begin
            return CCW'(CHUNK_MAX);
        end
        return CCW'(n);
    endfunction

    regblk_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (gap_arm),
        .expired (gap_expired)
    );

    regblk_retry_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .last_try (last_try)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (go) begin
                    st_nx = (len == 8'd0) ? S_FINISH : S_ADDR_W;
                end
            end
            S_ADDR_W: begin
                if (eng_done) begin
                    if (eng_nack) begin
                        st_nx = S_FAIL_STOP;
                    end else if (!leg_q) begin
                        st_nx = S_REG;
                    end else begin
                        st_nx = rd_q ? S_RX : S_DATA;
                    end
                end
            end
            S_REG: begin
                if (eng_done) begin
                    if (eng_nack) begin
                        st_nx = S_FAIL_STOP;
                    end else begin
                        st_nx = rd_q ? S_GAP : S_DATA;
                    end
                end
            end
            S_GAP: begin
                if (gap_expired) begin
                    st_nx = S_ADDR_R;
                end
            end
            S_ADDR_R: begin
                if (eng_done) begin
                    st_nx = eng_nack ? S_FAIL_STOP : S_RX;
                end
            end
            S_RX: begin
                if (eng_done && remain == 8'd1) begin
                    st_nx = S_FINISH;
                end
            end
            S_DATA: begin
                if (eng_done) begin
                    if (eng_nack) begin
                        st_nx = S_FAIL_STOP;
                    end else if (chunk_left == CCW'(1)) begin
                        st_nx = S_CHUNK_STOP;
                    end
                end
            end
            S_CHUNK_STOP: begin
                if (eng_done) begin
                    st_nx = S_POLL;
                end
            end
            S_POLL: begin
                if (eng_done) begin
                    if (!eng_nack) begin
                        st_nx = S_POLL_RD;
                    end else begin
                        st_nx = last_try ? S_FAIL_STOP : S_POLL_STOP;
                    end
                end
            end
            S_POLL_STOP: begin
                if (eng_done) begin
                    st_nx = S_POLL;
                end
            end
            S_POLL_RD: begin
                if (eng_done) begin
                    st_nx = (remain == 8'd0) ? S_FINISH : S_ADDR_W;
                end
            end
            S_FAIL_STOP: begin
                if (eng_done) begin
                    st_nx = S_FINISH;
                end
            end
            S_FINISH: st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q       <= 1'b0;
            leg_q      <= 1'b0;
            dev_q      <= '0;
            cur_reg    <= '0;
            remain     <= '0;
            chunk_left <= '0;
            ok_q       <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (go) begin
                        rd_q       <= is_read;
                        leg_q      <= legacy;
                        dev_q      <= dev_addr;
                        cur_reg    <= reg_addr;
                        remain     <= len;
                        chunk_left <= chunk_of(len);
                        ok_q       <= (len == 8'd0);
                    end
                end
                S_RX: begin
                    if (eng_done) begin
                        remain <= remain - 1'b1;
                        if (remain == 8'd1) begin
                            ok_q <= 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (eng_done && !eng_nack) begin
                        remain     <= remain - 1'b1;
                        chunk_left <= chunk_left - 1'b1;
                        cur_reg    <= cur_reg + 1'b1;
                    end
                end
                S_POLL_RD: begin
                    if (eng_done) begin
                        chunk_left <= chunk_of(remain);
                        if (remain == 8'd0) begin
                            ok_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        op_sel      = OP_STOP;
        eng_req     = 1'b0;
        eng_tx_byte = 8'h00;
        unique case (st)
            S_ADDR_W: begin
                eng_req     = 1'b1;
                op_sel      = OP_START_TX;
                eng_tx_byte = leg_q ? {cur_reg[6:0], rd_q} : {dev_q, 1'b0};
            end
            S_REG: begin
                eng_req     = 1'b1;
                op_sel      = OP_TX;
                eng_tx_byte = cur_reg;
            end
            S_ADDR_R, S_POLL: begin
                eng_req     = 1'b1;
                op_sel      = OP_START_TX;
                eng_tx_byte = {dev_q, 1'b1};
            end
            S_RX: begin
                eng_req = 1'b1;
                op_sel  = (remain == 8'd1) ? OP_RX_LAST : OP_RX_ACK;
            end
            S_DATA: begin
                eng_req     = 1'b1;
                op_sel      = OP_TX;
                eng_tx_byte = wr_byte;
            end
            S_POLL_RD: begin
                eng_req = 1'b1;
                op_sel  = OP_RX_LAST;
            end
            S_CHUNK_STOP, S_POLL_STOP, S_FAIL_STOP: begin
                eng_req = 1'b1;
                op_sel  = OP_STOP;
            end
            default: ;
        endcase
    end

    assign eng_op    = op_sel;
    assign gap_arm   = (st == S_REG) && eng_done && !eng_nack && rd_q;
    assign poll_clr  = (st == S_CHUNK_STOP) && eng_done;
    assign poll_inc  = (st == S_POLL) && eng_done && eng_nack;
    assign wr_pop    = (st == S_DATA) && eng_done && !eng_nack;
    assign rd_valid  = (st == S_RX) && eng_done;
    assign rd_byte   = eng_rx_byte;
    assign busy      = (st != S_IDLE);
    assign xfer_done = (st == S_FINISH);
    assign xfer_ok   = ok_q;
endmodule

// File: rtl/regblk_xfer_chk.sv
module regblk_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       xfer_done,
    input logic       wr_pop,
    input logic       rd_valid,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic [7:0] eng_tx_byte,
    input logic       eng_done,
    input logic       eng_nack
);
    // R3
    nack_then_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_nack) |=> (eng_req && eng_op == 3'd4));

    // R10
    req_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_tx_byte)));

    // R4
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && eng_done && !eng_nack));

    // R5
    pop_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (eng_done && !eng_nack && eng_op == 3'd1));

    // R11
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!busy && !xfer_done));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eng_req && !rd_valid && !wr_pop));
endmodule

bind regblk_xfer regblk_xfer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .xfer_done   (xfer_done),
    .wr_pop      (wr_pop),
    .rd_valid    (rd_valid),
    .eng_req     (eng_req),
    .eng_op      (eng_op),
    .eng_tx_byte (eng_tx_byte),
    .eng_done    (eng_done),
    .eng_nack    (eng_nack)
);

// File: tb/regblk_xfer_test.sv
`timescale 1ns/1ps
module regblk_xfer_test;
    localparam int GAP   = 25;
    localparam int LAT   = 2;
    localparam int LIMIT = 100;
    localparam logic [2:0] O_STX = 3'd0, O_TX = 3'd1, O_RXA = 3'd2, O_RXL = 3'd3, O_STOP = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0, is_read = 1'b0, legacy = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_addr = '0, len = '0;
    logic       busy, xfer_done, xfer_ok, wr_pop, rd_valid, eng_req;
    logic [7:0] wr_byte, rd_byte, eng_tx_byte;
    logic [2:0] eng_op;
    logic       eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] eng_rx_byte = '0;

    always #5 clk = ~clk;

    regblk_xfer #(.CHUNK_MAX(4), .POLL_LIMIT(LIMIT), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .is_read(is_read), .legacy(legacy),
        .dev_addr(dev_addr), .reg_addr(reg_addr), .len(len), .busy(busy),
        .xfer_done(xfer_done), .xfer_ok(xfer_ok), .wr_byte(wr_byte), .wr_pop(wr_pop),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .eng_req(eng_req), .eng_op(eng_op),
        .eng_tx_byte(eng_tx_byte), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rx_byte(eng_rx_byte)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // streams
    logic [7:0] wdata [0:255];
    logic [7:0] rbuf  [0:255];
    int  wr_idx = 0, rd_cnt = 0;
    logic clr = 1'b0;
    assign wr_byte = wdata[wr_idx[7:0]];
    always @(posedge clk) begin
        if (clr) begin
            wr_idx <= 0;
            rd_cnt <= 0;
        end else begin
            if (wr_pop) wr_idx <= wr_idx + 1;
            if (rd_valid) begin
                rbuf[rd_cnt[7:0]] <= rd_byte;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // device model and operation log
    logic [7:0] mem [0:255];
    logic [6:0] m_dev = 7'h50;
    bit   m_legacy = 0;
    int   m_busy_polls = 0, m_nack_idx = -1;
    int   poll_pending = 0, data_cnt = 0;
    bit   need_ptr = 0, wrote = 0;
    logic [7:0] ptr = 0;
    logic [2:0] log_op [0:511];
    logic [7:0] log_b  [0:511];
    int   log_t [0:511];
    int   log_n = 0;
    logic [2:0] exp_op [0:511];
    logic [7:0] exp_b  [0:511];
    int   exp_n = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        forever begin
            @(negedge clk);
            if (eng_req) begin
                logic [2:0] op;
                logic [7:0] b;
                logic nk;
                op = eng_op; b = eng_tx_byte; nk = 1'b0;
                if (log_n < 512) begin
                    log_op[log_n] = op; log_b[log_n] = b; log_t[log_n] = cyc;
                    log_n++;
                end
                repeat (LAT) @(negedge clk);
                case (op)
                    O_STX: begin
                        if (!m_legacy && b[7:1] != m_dev) nk = 1'b1;
                        else if (poll_pending > 0) begin
                            poll_pending--; nk = 1'b1;
                        end else begin
                            need_ptr = !m_legacy && !b[0];
                            if (m_legacy) ptr = {1'b0, b[7:1]};
                        end
                    end
                    O_TX: begin
                        if (need_ptr) begin
                            ptr = b; need_ptr = 0;
                        end else if (data_cnt == m_nack_idx) nk = 1'b1;
                        else begin
                            mem[ptr] = b; ptr = ptr + 1; wrote = 1; data_cnt++;
                        end
                    end
                    O_RXA, O_RXL: begin
                        eng_rx_byte = mem[ptr]; ptr = ptr + 1;
                    end
                    default: begin
                        if (wrote) poll_pending = m_busy_polls;
                        wrote = 0;
                    end
                endcase
                eng_nack = nk; eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0; eng_nack = 1'b0;
            end
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [7:0] b);
        exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
    endtask

    task automatic cmp_seq(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (bad < 0 && (log_op[i] != exp_op[i] ||
                ((exp_op[i] == O_STX || exp_op[i] == O_TX) && log_b[i] != exp_b[i])))
                bad = i;
        end
        if (log_n != exp_n) check(0, {req, " op count"}, log_n, exp_n);
        else if (bad >= 0) check(0, {req, " op/byte at step"}, {log_op[bad], log_b[bad]}, {exp_op[bad], exp_b[bad]});
        else check(1, req, 0, 0);
    endtask

    task automatic run(input bit rd, input bit leg, input logic [6:0] dv, input logic [7:0] ra,
                       input logic [7:0] n);
        int t;
        @(negedge clk);
        clr = 1'b1; log_n = 0; exp_n = 0; data_cnt = 0; poll_pending = 0; wrote = 0;
        m_legacy = leg;
        @(negedge clk);
        clr = 1'b0;
        is_read = rd; legacy = leg; dev_addr = dv; reg_addr = ra; len = n; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        t = 0;
        while (!xfer_done && t < 20000) begin
            @(negedge clk); t++;
        end
        check(t < 20000, "R11 watchdog", t, 20000);
        @(negedge clk);
    endtask

    task automatic build_write(input bit leg, input logic [6:0] dv, input logic [7:0] ra,
                               input int n, input int busyp);
        int rem, k, c;
        logic [7:0] a;
        rem = n; a = ra; k = 0;
        while (rem > 0) begin
            c = (rem > 4) ? 4 : rem;
            if (leg) push(O_STX, {a[6:0], 1'b0});
            else begin
                push(O_STX, {dv, 1'b0}); push(O_TX, a);
            end
            for (int i = 0; i < c; i++) push(O_TX, wdata[k + i]);
            push(O_STOP, 0);
            for (int p = 0; p < busyp; p++) begin
                push(O_STX, {dv, 1'b1}); push(O_STOP, 0);
            end
            push(O_STX, {dv, 1'b1}); push(O_RXL, 0);
            a = a + 8'(c); rem -= c; k += c;
        end
    endtask

    task automatic t_reset;
        check(!busy, "R11 reset busy", busy, 0);
        check(!xfer_done, "R11 reset done", xfer_done, 0);
        check(!eng_req, "R11 reset eng_req", eng_req, 0);
    endtask

    task automatic t_normal_read;
        int good;
        m_busy_polls = 0; m_nack_idx = -1;
        run(1, 0, 7'h50, 8'h40, 8'd3);
        push(O_STX, 8'hA0); push(O_TX, 8'h40); push(O_STX, 8'hA1);
        push(O_RXA, 0); push(O_RXA, 0); push(O_RXL, 0);
        cmp_seq("R1 R4 normal read sequence");
        good = (rd_cnt == 3) ? 1 : 0;
        for (int i = 0; i < 3; i++) if (rbuf[i] != mem[8'h40 + i]) good = 0;
        check(good == 1, "R4 read data", rd_cnt, 3);
        check(xfer_ok, "R4 read ok", xfer_ok, 1);
        check(log_t[2] - log_t[1] >= GAP + LAT, "R1 bus-free gap", log_t[2] - log_t[1], GAP + LAT);
    endtask

    task automatic t_legacy_read;
        run(1, 1, 7'h11, 8'h25, 8'd2);
        push(O_STX, 8'h4B); push(O_RXA, 0); push(O_RXL, 0);
        cmp_seq("R2 legacy read sequence");
        check(rd_cnt == 2 && rbuf[0] == mem[8'h25] && rbuf[1] == mem[8'h26],
              "R2 legacy read data", rbuf[0], mem[8'h25]);
        check(xfer_ok, "R2 legacy read ok", xfer_ok, 1);
    endtask

    task automatic t_write;
        int good;
        for (int i = 0; i < 6; i++) wdata[i] = 8'(8'hC0 + i);
        m_busy_polls = 3; m_nack_idx = -1;
        run(0, 0, 7'h50, 8'h10, 8'd6);
        build_write(0, 7'h50, 8'h10, 6, 3);
        cmp_seq("R5 R6 R7 chunked write sequence");
        good = 1;
        for (int i = 0; i < 6; i++) if (mem[8'h10 + i] != wdata[i]) good = 0;
        check(good == 1 && wr_idx == 6, "R5 written bytes", wr_idx, 6);
        check(xfer_ok, "R6 write ok", xfer_ok, 1);
        check(rd_cnt == 0, "R7 poll read discarded", rd_cnt, 0);
    endtask

    task automatic t_addr_nack;
        m_busy_polls = 0;
        run(1, 0, 7'h22, 8'h00, 8'd4);
        push(O_STX, {7'h22, 1'b0}); push(O_STOP, 0);
        cmp_seq("R3 address refused sequence");
        check(!xfer_ok, "R3 fail status", xfer_ok, 0);
    endtask

    task automatic t_data_nack;
        for (int i = 0; i < 6; i++) wdata[i] = 8'(8'h60 + i);
        m_busy_polls = 0; m_nack_idx = 1;
        run(0, 0, 7'h50, 8'h30, 8'd6);
        push(O_STX, 8'hA0); push(O_TX, 8'h30); push(O_TX, 8'h60); push(O_TX, 8'h61); push(O_STOP, 0);
        cmp_seq("R8 data refused sequence");
        check(!xfer_ok, "R8 fail status", xfer_ok, 0);
        check(mem[8'h30] == 8'h60 && wr_idx == 1, "R8 one byte popped", wr_idx, 1);
        m_nack_idx = -1;
    endtask

    task automatic t_poll_limit;
        wdata[0] = 8'h5A;
        m_busy_polls = 150;
        run(0, 0, 7'h50, 8'h90, 8'd1);
        push(O_STX, 8'hA0); push(O_TX, 8'h90); push(O_TX, 8'h5A); push(O_STOP, 0);
        for (int p = 0; p < LIMIT; p++) begin
            push(O_STX, 8'hA1); push(O_STOP, 0);
        end
        cmp_seq("R6 poll limit sequence");
        check(!xfer_ok, "R6 poll limit fail", xfer_ok, 0);
        m_busy_polls = 0;
    endtask

    task automatic t_zero;
        run(0, 0, 7'h50, 8'h00, 8'd0);
        check(xfer_ok, "R9 zero length ok", xfer_ok, 1);
        check(log_n == 0, "R9 no engine ops", log_n, 0);
    endtask

    task automatic t_legacy_write;
        int good;
        for (int i = 0; i < 5; i++) wdata[i] = 8'(8'h31 * (i + 1));
        m_busy_polls = 1;
        run(0, 1, 7'h50, 8'h08, 8'd5);
        build_write(1, 7'h50, 8'h08, 5, 1);
        cmp_seq("R2 R5 legacy write sequence");
        good = 1;
        for (int i = 0; i < 5; i++) if (mem[8'h08 + i] != wdata[i]) good = 0;
        check(good == 1, "R5 legacy written bytes", mem[8'h08], wdata[0]);
        check(xfer_ok, "R5 legacy write ok", xfer_ok, 1);
        m_busy_polls = 0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                t_normal_read();
                t_legacy_read();
                t_write();
                t_addr_nack();
                t_data_nack();
                t_poll_limit();
                t_zero();
                t_legacy_write();
            end
            begin
                repeat (150000) @(posedge clk);
                check(0, "R11 global watchdog", 150000, 0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule